// File: doc/BRIEF.md
# Multi-channel two-cycle DMA controller

This block moves data between locations on a shared memory bus on behalf of several independent channels. Software sets up a channel through a small register write port: the address to read from, the address to write to, how many units to move, and whether each unit is a byte or a halfword. Once enabled, the channel moves data whenever its request input is high. It raises a terminal-count flag and a one-clock interrupt when its count runs out.

Every unit takes two bus cycles. The first reads from the source into an internal holding register. The second writes that value to the destination. The controller asks for the bus, performs exactly one unit, and then drops its request for at least one clock. It then picks the highest-priority pending channel again. A low-priority channel with a long transfer therefore cannot hold off a more urgent channel for more than one unit.

Channel 0 has the highest priority. A halfword channel whose source or destination address is odd is flagged as faulty and stopped before it touches the bus.

Top module: `dma2c_top`

## Requirements
- R1: Each unit is a read cycle (`bus_we`=0) at the channel's source address, followed directly by a write cycle (`bus_we`=1) at its destination address. The write cycle carries the data that the read cycle returned.
- R2: `bus_size` is 1 for a halfword channel and 0 for a byte channel. A halfword moves all 16 bits, with byte address order little-endian. A byte unit writes only `bus_rdata[7:0]`: `bus_wdata[15:8]` is zero on its write cycle.
- R3: After each unit, the source and destination addresses both advance by 1 for a byte channel or by 2 for a halfword channel, and the count drops by one. While the request stays high, the channel keeps moving units until its count reaches zero. After that it moves nothing more, even if the request stays high.
- R4: `bus_req` goes low for at least one clock after every completed write cycle, so the bus is released after each unit.
- R5: Priority is fixed, with the lowest channel number winning. A choice is made only while the bus is released. A higher-priority channel whose request rises between units of a lower-priority channel is served before that lower channel's next unit.
- R6: `bus_cyc` is high only while `bus_gnt` is high. While `bus_cyc` is high and `bus_ready` is low, the address, the direction and the cycle itself stay unchanged (wait states).
- R7: When a channel's count reaches zero, its `tc_flag` bit sets, the channel disables itself, and its `irq` bit is high for exactly one clock.
- R8: A halfword channel with an odd source or destination address sets its `err_flag` bit and is disabled, and no bus activity takes place for it. The bus never carries a halfword cycle at an odd address.
- R9: A channel that is not enabled, or whose count is zero, causes no bus activity even when its request is high.
- R10: A write to the config port (`cfg_we`=1) targets the channel given by `cfg_ch`. `cfg_sel` selects the field: 0 is the source address, 1 is the destination address, 2 is the count, and 3 is the control field. In the control field, bit 0 enables the channel and bit 1 selects halfword. Writing the control field clears that channel's `tc_flag` and `err_flag` bits.
- R11: After reset, `bus_req`, `bus_cyc`, `tc_flag`, `err_flag` and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Config write strobe |
| cfg_ch | input | CHW | Channel targeted by the config write |
| cfg_sel | input | 2 | Field select: 0 source, 1 destination, 2 count, 3 control |
| cfg_wdata | input | AW | Config write data |
| dreq | input | N_CH | Per-channel transfer request (level) |
| bus_req | output | 1 | Bus request, held for one unit |
| bus_gnt | input | 1 | Bus grant |
| bus_cyc | output | 1 | A bus cycle is in progress |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_size | output | 1 | 1 for halfword, 0 for byte |
| bus_addr | output | AW | Byte address of the current cycle |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data |
| bus_ready | input | 1 | Ends the current cycle at the next edge |
| tc_flag | output | N_CH | Terminal-count flags |
| err_flag | output | N_CH | Misaligned-address error flags |
| irq | output | N_CH | One-clock terminal-count interrupt |

## Verification
The bound checker checks the bus rules on every clock:
- a cycle appears only under grant;
- address and direction hold through wait states;
- each read is followed at once by a write;
- the request drops after each write;
- no halfword cycle occurs at an odd address;
- the interrupt is a single-clock pulse that comes only together with a set terminal-count flag.

Only the bench scenarios can show the following:
- that the data and the addresses are the right ones, including the byte masking;
- that a channel stops at exactly its count;
- the order in which competing channels are served, including a cut-in between two units;
- that a faulty, disabled or zero-count channel stays silent.

// File: rtl/dma2c_pkg.sv
package dma2c_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_RD   = 2'd2,
        ST_WR   = 2'd3
    } dma2c_state_e;

    // config field selects
    localparam logic [1:0] FLD_SRC  = 2'd0;
    localparam logic [1:0] FLD_DST  = 2'd1;
    localparam logic [1:0] FLD_CNT  = 2'd2;
    localparam logic [1:0] FLD_CTRL = 2'd3;

    // control field bit positions
    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_HW_BIT = 1;

endpackage

// File: rtl/dma2c_arb.sv
// Fixed-priority picker: lowest index wins.
module dma2c_arb #(
    parameter int N_CH = 4,
    parameter int CHW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic [N_CH-1:0] req,
    output logic            any,
    output logic [CHW-1:0]  idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N_CH - 1; i >= 0; i--) begin
            if (req[i]) idx = CHW'(i);
        end
    end
endmodule

// File: rtl/dma2c_chan.sv
// One channel's configuration and progress state.
module dma2c_chan
    import dma2c_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          step,
    input  logic          fault,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [CW-1:0] cnt_o,
    output logic          en_o,
    output logic          hw_o,
    output logic          tc_o,
    output logic          err_o,
    output logic          irq_o
);
    typedef struct packed {
        logic [AW-1:0] src;
        logic [AW-1:0] dst;
        logic [CW-1:0] cnt;
        logic          en;
        logic          hw;
        logic          tc;
        logic          err;
        logic          irq;
    } chan_t;

    chan_t ch_d, ch_q;
    logic [AW-1:0] inc;

    always_comb begin
        ch_d     = ch_q;
        ch_d.irq = 1'b0;
        inc      = ch_q.hw ? AW'(2) : AW'(1);
        if (wr_en) begin
            unique case (wr_sel)
                FLD_SRC:  ch_d.src = wr_data;
                FLD_DST:  ch_d.dst = wr_data;
                FLD_CNT:  ch_d.cnt = wr_data[CW-1:0];
                default: begin
                    ch_d.en  = wr_data[CTRL_EN_BIT];
                    ch_d.hw  = wr_data[CTRL_HW_BIT];
                    ch_d.tc  = 1'b0;
                    ch_d.err = 1'b0;
                end
            endcase
        end
        if (fault) begin
            ch_d.err = 1'b1;
            ch_d.en  = 1'b0;
        end
        if (step) begin
            ch_d.src = ch_q.src + inc;
            ch_d.dst = ch_q.dst + inc;
            ch_d.cnt = ch_q.cnt - CW'(1);
            if (ch_q.cnt == CW'(1)) begin
                ch_d.tc  = 1'b1;
                ch_d.en  = 1'b0;
                ch_d.irq = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign src_o = ch_q.src;
    assign dst_o = ch_q.dst;
    assign cnt_o = ch_q.cnt;
    assign en_o  = ch_q.en;
    assign hw_o  = ch_q.hw;
    assign tc_o  = ch_q.tc;
    assign err_o = ch_q.err;
    assign irq_o = ch_q.irq;
endmodule

// File: rtl/dma2c_top.sv
module dma2c_top
    import dma2c_pkg::*;
#(
    parameter int N_CH = 4,
    parameter int AW   = 16,
    parameter int CW   = 8,
    parameter int CHW  = (N_CH > 1) ? $clog2(N_CH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CHW-1:0]  cfg_ch,
    input  logic [1:0]      cfg_sel,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic [N_CH-1:0] dreq,
    output logic            bus_req,
    input  logic            bus_gnt,
    output logic            bus_cyc,
    output logic            bus_we,
    output logic            bus_size,
    output logic [AW-1:0]   bus_addr,
    output logic [15:0]     bus_wdata,
    input  logic [15:0]     bus_rdata,
    input  logic            bus_ready,
    output logic [N_CH-1:0] tc_flag,
    output logic [N_CH-1:0] err_flag,
    output logic [N_CH-1:0] irq
);
    localparam int DW = 16;

    typedef struct packed {
        dma2c_state_e   st;
        logic [CHW-1:0] cur;
        logic [DW-1:0]  hold;
    } ctl_t;

    ctl_t c_d, c_q;

    logic [AW-1:0]   ch_src [N_CH];
    logic [AW-1:0]   ch_dst [N_CH];
    logic [CW-1:0]   ch_cnt [N_CH];
    logic [N_CH-1:0] ch_en, ch_hw, eligible, step, fault;
    logic            pick_any, misalign, unit_done;
    logic [CHW-1:0]  pick_idx;

    assign unit_done = (c_q.st == ST_WR) && bus_ready;
    assign misalign  = ch_hw[pick_idx] &&
                       (ch_src[pick_idx][0] || ch_dst[pick_idx][0]);

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        dma2c_chan #(.AW(AW), .CW(CW)) i_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (cfg_we && (cfg_ch == CHW'(g))),
            .wr_sel (cfg_sel),
            .wr_data(cfg_wdata),
            .step   (step[g]),
            .fault  (fault[g]),
            .src_o  (ch_src[g]),
            .dst_o  (ch_dst[g]),
            .cnt_o  (ch_cnt[g]),
            .en_o   (ch_en[g]),
            .hw_o   (ch_hw[g]),
            .tc_o   (tc_flag[g]),
            .err_o  (err_flag[g]),
            .irq_o  (irq[g])
        );
        assign eligible[g] = ch_en[g] && dreq[g] && (ch_cnt[g] != '0);
        assign step[g]     = unit_done && (c_q.cur == CHW'(g));
        assign fault[g]    = (c_q.st == ST_IDLE) && pick_any && misalign &&
                             (pick_idx == CHW'(g));
    end

    dma2c_arb #(.N_CH(N_CH), .CHW(CHW)) i_arb (
        .req(eligible),
        .any(pick_any),
        .idx(pick_idx)
    );

    // unit sequencer
    always_comb begin
        c_d = c_q;
        unique case (c_q.st)
            ST_IDLE: begin
                if (pick_any && !misalign) begin
                    c_d.cur = pick_idx;
                    c_d.st  = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_gnt) c_d.st = ST_RD;
            end
            ST_RD: begin
                if (bus_ready) begin
                    c_d.hold = ch_hw[c_q.cur] ? bus_rdata : {8'h00, bus_rdata[7:0]};
                    c_d.st   = ST_WR;
                end
            end
            default: begin
                if (bus_ready) c_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '{st: ST_IDLE, cur: '0, hold: '0};
        else        c_q <= c_d;
    end

    assign bus_req   = (c_q.st != ST_IDLE);
    assign bus_cyc   = (c_q.st == ST_RD) || (c_q.st == ST_WR);
    assign bus_we    = (c_q.st == ST_WR);
    assign bus_size  = ch_hw[c_q.cur];
    assign bus_addr  = (c_q.st == ST_WR) ? ch_dst[c_q.cur] : ch_src[c_q.cur];
    assign bus_wdata = c_q.hold;
endmodule

// File: rtl/dma2c_chk.sv
module dma2c_chk #(
    parameter int N_CH = 4,
    parameter int AW   = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_req,
    input logic            bus_gnt,
    input logic            bus_cyc,
    input logic            bus_we,
    input logic            bus_size,
    input logic [AW-1:0]   bus_addr,
    input logic            bus_ready,
    input logic [N_CH-1:0] tc_flag,
    input logic [N_CH-1:0] irq
);
    p_rd_then_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_we && bus_ready) |=> (bus_cyc && bus_we));

    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_we && bus_ready) |=> !bus_req);

    p_cyc_gnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> bus_gnt);

    p_wait_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ready) |=>
            (bus_cyc && $stable(bus_addr) && $stable(bus_we)));

    p_hw_even_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && bus_size) |-> !bus_addr[0]);

    p_irq_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(irq));

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |=> !(|irq));

    for (genvar g = 0; g < N_CH; g++) begin : g_irq
        p_irq_tc_r7: assert property (@(posedge clk) disable iff (!rst_n)
            irq[g] |-> tc_flag[g]);
    end
endmodule

bind dma2c_top dma2c_chk #(.N_CH(N_CH), .AW(AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_gnt  (bus_gnt),
    .bus_cyc  (bus_cyc),
    .bus_we   (bus_we),
    .bus_size (bus_size),
    .bus_addr (bus_addr),
    .bus_ready(bus_ready),
    .tc_flag  (tc_flag),
    .irq      (irq)
);

// File: tb/test_dma2c_top.sv
`timescale 1ns/1ps
module test_dma2c_top;
    localparam int N_CH = 4;
    localparam int AW   = 16;
    localparam int CW   = 8;
    localparam int CHW  = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [CHW-1:0]  cfg_ch = '0;
    logic [1:0]      cfg_sel = '0;
    logic [AW-1:0]   cfg_wdata = '0;
    logic [N_CH-1:0] dreq = '0;
    logic            bus_req, bus_cyc, bus_we, bus_size;
    logic            bus_gnt = 1'b0;
    logic [AW-1:0]   bus_addr;
    logic [15:0]     bus_wdata;
    logic [15:0]     bus_rdata = '0;
    logic            bus_ready = 1'b0;
    logic [N_CH-1:0] tc_flag, err_flag, irq;

    always #4 clk = ~clk;

    dma2c_top #(.N_CH(N_CH), .AW(AW), .CW(CW)) i_dma2c_top (
        .clk, .rst_n, .cfg_we, .cfg_ch, .cfg_sel, .cfg_wdata, .dreq,
        .bus_req, .bus_gnt, .bus_cyc, .bus_we, .bus_size, .bus_addr,
        .bus_wdata, .bus_rdata, .bus_ready, .tc_flag, .err_flag, .irq
    );

    typedef struct {
        logic [AW-1:0] addr;
        logic          we;
        logic          size;
        logic [15:0]   data;
    } item_t;

    item_t exp_q[$];
    logic [7:0] mem [0:65535];
    int checks = 0, errors = 0;
    int lat = 0, wcnt = 0, req_rise = 0;
    int irq_cnt [N_CH];
    logic req_prev = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // driver side: push the two expected bus cycles of one unit
    task automatic exp_unit(input logic [AW-1:0] s, input logic [AW-1:0] d, input bit hw);
        item_t it;
        logic [15:0] v;
        v = hw ? {mem[16'(s + 1)], mem[s]} : {8'h00, mem[s]};
        it.addr = s; it.we = 1'b0; it.size = hw; it.data = v;
        exp_q.push_back(it);
        it.addr = d; it.we = 1'b1;
        exp_q.push_back(it);
    endtask

    // memory model, grant model and monitor
    always @(negedge clk) begin
        bus_gnt = bus_req;
        if (bus_req && !req_prev) req_rise++;
        req_prev = bus_req;
        for (int i = 0; i < N_CH; i++) irq_cnt[i] += int'(irq[i]);
        if (bus_ready) begin
            bus_ready = 1'b0;
            wcnt = lat;
        end else if (bus_cyc) begin
            if (wcnt > 0) wcnt--;
            else begin
                bus_ready = 1'b1;
                if (!bus_we)
                    bus_rdata = bus_size ? {mem[16'(bus_addr + 1)], mem[bus_addr]}
                                         : {8'hA5, mem[bus_addr]};
                else begin
                    mem[bus_addr] = bus_wdata[7:0];
                    if (bus_size) mem[16'(bus_addr + 1)] = bus_wdata[15:8];
                end
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected bus cycle at addr", int'(bus_addr), 0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    chk(bus_addr == e.addr, "R1 cycle address", int'(bus_addr), int'(e.addr));
                    chk(bus_we == e.we, "R1 read-then-write order", int'(bus_we), int'(e.we));
                    chk(bus_size == e.size, "R2 cycle size", int'(bus_size), int'(e.size));
                    if (bus_we)
                        chk(bus_wdata == e.data, "R2 write data", int'(bus_wdata), int'(e.data));
                end
            end
        end
    end

    task automatic cfg_write(input int ch, input logic [1:0] sel, input logic [AW-1:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R10: sel 0 src, 1 dst, 2 count, 3 control {hw, en}
    task automatic prog(input int ch, input logic [AW-1:0] s, input logic [AW-1:0] d,
                        input int cnt, input bit hw, input bit en);
        cfg_write(ch, 2'd0, s);
        cfg_write(ch, 2'd1, d);
        cfg_write(ch, 2'd2, AW'(cnt));
        cfg_write(ch, 2'd3, {14'd0, hw, en});
    endtask

    task automatic wait_done();
        int n = 0;
        while ((exp_q.size() != 0 || bus_req) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(exp_q.size() == 0, "R3 expected cycles left over", exp_q.size(), 0);
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int r0;
        for (int i = 0; i < 65536; i++) mem[i] = 8'(i * 7 + 3);
        for (int i = 0; i < N_CH; i++) irq_cnt[i] = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(bus_req == 1'b0, "R11 bus_req after reset", int'(bus_req), 0);
        chk(bus_cyc == 1'b0, "R11 bus_cyc after reset", int'(bus_cyc), 0);
        chk(tc_flag == '0 && err_flag == '0 && irq == '0, "R11 flags after reset",
            int'({tc_flag, err_flag, irq}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // byte channel, request held past the count (R1 R2 R3 R4 R7)
        lat = 0; wcnt = 0;
        prog(1, 16'h1000, 16'h2000, 3, 1'b0, 1'b1);
        for (int k = 0; k < 3; k++) exp_unit(16'(16'h1000 + k), 16'(16'h2000 + k), 1'b0);
        r0 = req_rise;
        dreq[1] = 1'b1;
        wait_done();
        repeat (20) @(negedge clk);
        chk(req_rise - r0 == 3, "R4 one bus request per unit", req_rise - r0, 3);
        chk(tc_flag[1] == 1'b1, "R7 tc flag ch1", int'(tc_flag[1]), 1);
        chk(irq_cnt[1] == 1, "R7 single irq pulse ch1", irq_cnt[1], 1);
        chk(mem[16'h2002] == 8'(16'h1002 * 7 + 3), "R3 last byte moved",
            int'(mem[16'h2002]), int'(8'(16'h1002 * 7 + 3)));
        dreq[1] = 1'b0;

        // halfword channel with wait states (R2 R3 R6)
        lat = 2; wcnt = 2;
        prog(0, 16'h3000, 16'h4000, 2, 1'b1, 1'b1);
        exp_unit(16'h3000, 16'h4000, 1'b1);
        exp_unit(16'h3002, 16'h4002, 1'b1);
        dreq[0] = 1'b1;
        wait_done();
        chk({mem[16'h4003], mem[16'h4002]} == {mem[16'h3003], mem[16'h3002]},
            "R2 halfword copied", int'({mem[16'h4003], mem[16'h4002]}),
            int'({mem[16'h3003], mem[16'h3002]}));
        chk(tc_flag[0] == 1'b1, "R7 tc flag ch0", int'(tc_flag[0]), 1);
        dreq[0] = 1'b0;

        // simultaneous requests: lower number first (R5)
        lat = 0; wcnt = 0;
        prog(2, 16'h0100, 16'h0200, 2, 1'b0, 1'b1);
        prog(3, 16'h0300, 16'h0400, 2, 1'b1, 1'b1);
        exp_unit(16'h0100, 16'h0200, 1'b0);
        exp_unit(16'h0101, 16'h0201, 1'b0);
        exp_unit(16'h0300, 16'h0400, 1'b1);
        exp_unit(16'h0302, 16'h0402, 1'b1);
        @(negedge clk);
        dreq[2] = 1'b1; dreq[3] = 1'b1;
        wait_done();
        chk(tc_flag[3:2] == 2'b11, "R5 both channels finished", int'(tc_flag[3:2]), 3);
        dreq[3:2] = 2'b00;

        // cut-in between units of a lower channel (R5, R10)
        lat = 1; wcnt = 1;
        prog(1, 16'h5000, 16'h5800, 3, 1'b0, 1'b1);
        chk(tc_flag[1] == 1'b0, "R10 control write clears tc", int'(tc_flag[1]), 0);
        prog(0, 16'h6000, 16'h6800, 2, 1'b1, 1'b1);
        exp_unit(16'h5000, 16'h5800, 1'b0);
        exp_unit(16'h6000, 16'h6800, 1'b1);
        exp_unit(16'h6002, 16'h6802, 1'b1);
        exp_unit(16'h5001, 16'h5801, 1'b0);
        exp_unit(16'h5002, 16'h5802, 1'b0);
        @(negedge clk);
        dreq[1] = 1'b1;
        do @(negedge clk); while (!bus_req);
        do @(negedge clk); while (bus_req);
        dreq[0] = 1'b1;
        wait_done();
        chk(tc_flag[1:0] == 2'b11, "R5 cut-in both done", int'(tc_flag[1:0]), 3);
        dreq[1:0] = 2'b00;

        // misaligned halfword channel (R8)
        r0 = req_rise;
        prog(2, 16'h7001, 16'h7100, 2, 1'b1, 1'b1);
        chk(tc_flag[2] == 1'b0, "R10 control write clears tc ch2", int'(tc_flag[2]), 0);
        dreq[2] = 1'b1;
        repeat (12) @(negedge clk);
        chk(err_flag[2] == 1'b1, "R8 error flag set", int'(err_flag[2]), 1);
        chk(req_rise == r0, "R8 no bus request", req_rise - r0, 0);
        chk(mem[16'h7100] == 8'(16'h7100 * 7 + 3), "R8 destination untouched",
            int'(mem[16'h7100]), int'(8'(16'h7100 * 7 + 3)));
        dreq[2] = 1'b0;
        cfg_write(2, 2'd3, 16'h0000);
        chk(err_flag[2] == 1'b0, "R10 control write clears err", int'(err_flag[2]), 0);

        // zero count and disabled channel stay silent (R9)
        r0 = req_rise;
        prog(3, 16'h0500, 16'h0600, 0, 1'b0, 1'b1);
        prog(1, 16'h0700, 16'h0800, 2, 1'b0, 1'b0);
        dreq[3] = 1'b1; dreq[1] = 1'b1;
        repeat (20) @(negedge clk);
        chk(req_rise == r0, "R9 no request from idle channels", req_rise - r0, 0);
        chk(tc_flag[3] == 1'b0 && err_flag[3] == 1'b0, "R9 zero-count flags",
            int'({tc_flag[3], err_flag[3]}), 0);
        dreq = '0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule